// File: doc/BRIEF.md
# Coprocessor-2 Instruction Decode and Transfer Unit

This unit sits beside the integer pipeline of a MIPS-style core. It takes bits 25:0 of each instruction that the major opcode has already steered to coprocessor 2. It classifies the word and finishes the simple cases itself.

Conditional branches are resolved against a busy flag from an attached vector unit. The unit returns the taken flag, the next PC and, for the likely variants, a strobe that squashes the following instruction.

Control-register and vector-register moves become single-word accesses on a register bus. Each register index maps to a bus address at a 16-byte stride from one of two base addresses. A move may carry an interlock bit. When that bit is set, the access waits until the vector unit reports idle. A word read from the bus is sign-extended to 64 bits and written back to a general register.

Every accepted instruction ends with one `done` pulse. That pulse carries the results or one of two exception strobes: coprocessor unusable or reserved instruction. While a move is in flight, `stall` is high and new instructions are not accepted.

Top module: `cp2_issue_unit`

## Requirements
- R1: After synchronous reset, `done`, `stall`, `bus_req`, `gpr_we`, `br_taken`, `nullify_next`, `exc_unusable` and `exc_reserved` are all 0.
- R2: When `cu2_usable` is 0, an accepted instruction produces, one cycle later, `done` with `exc_unusable`. It produces no bus request and no register write.
- R3: Field insn[25:21]=0x08 with insn[20:16] in 0..3 is a branch. Values 0 and 2 are taken when `vu_busy` is 0 at acceptance; values 1 and 3 are taken when it is 1. The result arrives with `done` one cycle after acceptance.
- R4: The branch target is PC+4 plus the sign-extended insn[15:0] shifted left by 2. `next_pc` is the target when the branch is taken and PC+4 otherwise, including for moves and exceptions.
- R5: `nullify_next` is 1 exactly for forms 2 and 3 (insn[17]=1) when the branch is not taken.
- R6: insn[25:21]=0x02 (read) or 0x06 (write) with insn[10:1]=0 is a control move. Its bus address is CTRL_BASE + 16*insn[15:11].
- R7: insn[25:21]=0x01 (read) or 0x05 (write) is a vector move, whatever insn[10:1] holds. Its bus address is VEC_BASE + 16*insn[15:11].
- R8: A write move issues one `bus_req` cycle with `bus_we`=1 and `bus_wdata`=`gpr_rdata` sampled at acceptance. `done` is raised in that same cycle.
- R9: A read move issues one `bus_req` cycle with `bus_we`=0. In the next cycle it raises `gpr_we` and `done`, with `gpr_waddr`=insn[20:16] and `gpr_wdata` set to `bus_rdata` sign-extended to 64 bits.
- R10: For a move with insn[0]=1, `bus_req` is raised one cycle after the first clock edge following acceptance at which `vu_busy` is 0.
- R11: For a move with insn[0]=0, `bus_req` is raised two cycles after acceptance, whatever `vu_busy` holds.
- R12: Any other encoding raises `exc_reserved` with `done` one cycle after acceptance, with no bus request and no register write. This covers insn[25:21]=0x08 with insn[20:16]>3, and a control move with insn[10:1] nonzero.
- R13: `stall` is 1 from the cycle after a move is accepted until its `done`. While `stall` is 1, `insn_valid` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction presented this cycle |
| insn | input | 26 | Instruction bits 25:0 |
| insn_pc | input | PC_W | PC of the instruction |
| cu2_usable | input | 1 | Coprocessor-2 usable status bit |
| vu_busy | input | 1 | Vector unit busy flag |
| gpr_rdata | input | 32 | Low word of general register insn[20:16] |
| bus_rdata | input | 32 | Read data, valid the cycle after a read request |
| stall | output | 1 | Move in flight, input ignored |
| done | output | 1 | Instruction complete |
| next_pc | output | PC_W | Next PC, valid with done |
| br_taken | output | 1 | Branch taken, valid with done |
| nullify_next | output | 1 | Squash next instruction |
| exc_unusable | output | 1 | Coprocessor-unusable exception |
| exc_reserved | output | 1 | Reserved-instruction exception |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | Request is a write |
| bus_addr | output | AW | Register bus byte address |
| bus_wdata | output | 32 | Write data |
| gpr_we | output | 1 | General register write strobe |
| gpr_waddr | output | 5 | General register index |
| gpr_wdata | output | 64 | Sign-extended write-back value |

## Verification
The assertions assume three things about the inputs:
- the core drops `insn_valid` when `done` appears;
- the register bus returns read data in the cycle right after a read request;
- the two bases are 16-byte aligned.

The bench answers every read from a bus model one cycle after the request. It holds `insn_valid` for a single cycle except in one directed case, which deliberately drives it during a stall. Random instructions mix legal and illegal field values with random busy durations. Busy is capped for interlocked moves so that every run completes.

// File: rtl/cp2_pkg.sv
package cp2_pkg;

  localparam logic [4:0] OPF_BRANCH = 5'h08;
  localparam logic [4:0] OPF_CRD    = 5'h02;
  localparam logic [4:0] OPF_CWR    = 5'h06;
  localparam logic [4:0] OPF_VRD    = 5'h01;
  localparam logic [4:0] OPF_VWR    = 5'h05;

  typedef enum logic [2:0] {
    CK_UNUSABLE,
    CK_BRANCH,
    CK_CTRL,
    CK_VEC,
    CK_RESERVED
  } cp2_kind_e;

  typedef struct packed {
    cp2_kind_e   kind;
    logic        to_unit;
    logic        likely;
    logic        on_busy;
    logic        lock;
    logic [4:0]  gpr;
    logic [4:0]  idx;
    logic [15:0] offs;
  } cp2_dec_t;

endpackage

// File: rtl/cp2_field_decode.sv
module cp2_field_decode
  import cp2_pkg::*;
(
  input  logic [25:0] insn,
  input  logic        cu_en,
  output cp2_dec_t    dec
);
  logic [4:0] major;
  logic [4:0] sub;
  logic       mid_zero;

  assign major    = insn[25:21];
  assign sub      = insn[20:16];
  assign mid_zero = (insn[10:1] == 10'd0);

  always_comb begin
    dec.gpr     = insn[20:16];
    dec.idx     = insn[15:11];
    dec.offs    = insn[15:0];
    dec.lock    = insn[0];
    dec.likely  = sub[1];
    dec.on_busy = sub[0];
    dec.to_unit = (major == OPF_CWR) || (major == OPF_VWR);
    if (!cu_en)
      dec.kind = CK_UNUSABLE;
    else if (major == OPF_BRANCH && sub[4:2] == 3'd0)
      dec.kind = CK_BRANCH;
    else if ((major == OPF_CRD || major == OPF_CWR) && mid_zero)
      dec.kind = CK_CTRL;
    else if (major == OPF_VRD || major == OPF_VWR)
      dec.kind = CK_VEC;
    else
      dec.kind = CK_RESERVED;
  end
endmodule

// File: rtl/cp2_branch_eval.sv
module cp2_branch_eval
  import cp2_pkg::*;
#(
  parameter int PC_W = 32
) (
  input  cp2_dec_t        dec,
  input  logic [PC_W-1:0] pc,
  input  logic            unit_busy,
  output logic            taken,
  output logic            squash,
  output logic [PC_W-1:0] seq_pc,
  output logic [PC_W-1:0] target
);
  localparam int EXT_W = PC_W - 18;

  logic [PC_W-1:0] disp;

  assign disp   = {{EXT_W{dec.offs[15]}}, dec.offs, 2'b00};
  assign seq_pc = pc + PC_W'(4);
  assign target = seq_pc + disp;
  assign taken  = (dec.kind == CK_BRANCH) && (dec.on_busy == unit_busy);
  assign squash = (dec.kind == CK_BRANCH) && dec.likely && !taken;
endmodule

// File: rtl/cp2_xfer_engine.sv
module cp2_xfer_engine
  import cp2_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          GW        = 64,
  parameter int          STRIDE_LG = 4,
  parameter logic [31:0] CTRL_BASE = 32'h0000_1000,
  parameter logic [31:0] VEC_BASE  = 32'h0000_1200
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  cp2_dec_t      dec,
  input  logic [31:0]   src_word,
  input  logic          unit_busy,
  input  logic [31:0]   rd_word,
  output logic          pending,
  output logic          req,
  output logic          req_we,
  output logic [AW-1:0] req_addr,
  output logic [31:0]   req_wdata,
  output logic          wb_en,
  output logic [4:0]    wb_idx,
  output logic [GW-1:0] wb_data,
  output logic          fin
);
  typedef enum logic [1:0] {X_IDLE, X_WAIT, X_READ} xstate_e;

  localparam logic [AW-1:0] CB = AW'(CTRL_BASE);
  localparam logic [AW-1:0] VB = AW'(VEC_BASE);

  xstate_e         st;
  logic            hold_lock;
  logic            hold_we;
  logic [AW-1:0]   hold_addr;
  logic [31:0]     hold_data;
  logic [AW-1:0]   base_sel;

  assign base_sel = (dec.kind == CK_CTRL) ? CB : VB;
  assign pending  = (st != X_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= X_IDLE;
      hold_lock <= 1'b0;
      hold_we   <= 1'b0;
      hold_addr <= '0;
      hold_data <= '0;
      req       <= 1'b0;
      req_we    <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      wb_en     <= 1'b0;
      wb_idx    <= '0;
      wb_data   <= '0;
      fin       <= 1'b0;
    end else begin
      req   <= 1'b0;
      wb_en <= 1'b0;
      fin   <= 1'b0;
      unique case (st)
        X_IDLE: begin
          if (start) begin
            hold_lock <= dec.lock;
            hold_we   <= dec.to_unit;
            hold_addr <= base_sel + (AW'(dec.idx) << STRIDE_LG);
            hold_data <= src_word;
            wb_idx    <= dec.gpr;
            st        <= X_WAIT;
          end
        end
        X_WAIT: begin
          if (!(hold_lock && unit_busy)) begin
            req       <= 1'b1;
            req_we    <= hold_we;
            req_addr  <= hold_addr;
            req_wdata <= hold_data;
            if (hold_we) begin
              fin <= 1'b1;
              st  <= X_IDLE;
            end else begin
              st <= X_READ;
            end
          end
        end
        X_READ: begin
          wb_en   <= 1'b1;
          wb_data <= {{(GW-32){rd_word[31]}}, rd_word};
          fin     <= 1'b1;
          st      <= X_IDLE;
        end
        default: st <= X_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cp2_issue_unit.sv
module cp2_issue_unit
  import cp2_pkg::*;
#(
  parameter int          PC_W      = 32,
  parameter int          AW        = 32,
  parameter int          GW        = 64,
  parameter int          STRIDE_LG = 4,
  parameter logic [31:0] CTRL_BASE = 32'h0000_1000,
  parameter logic [31:0] VEC_BASE  = 32'h0000_1200
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            insn_valid,
  input  logic [25:0]     insn,
  input  logic [PC_W-1:0] insn_pc,
  input  logic            cu2_usable,
  input  logic            vu_busy,
  input  logic [31:0]     gpr_rdata,
  input  logic [31:0]     bus_rdata,
  output logic            stall,
  output logic            done,
  output logic [PC_W-1:0] next_pc,
  output logic            br_taken,
  output logic            nullify_next,
  output logic            exc_unusable,
  output logic            exc_reserved,
  output logic            bus_req,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [31:0]     bus_wdata,
  output logic            gpr_we,
  output logic [4:0]      gpr_waddr,
  output logic [GW-1:0]   gpr_wdata
);
  cp2_dec_t        dec;
  logic            accept;
  logic            is_move;
  logic            br_take;
  logic            br_squash;
  logic [PC_W-1:0] pc_seq;
  logic [PC_W-1:0] pc_tgt;
  logic            x_fin;
  logic            local_done;

  cp2_field_decode u_dec (
    .insn  (insn),
    .cu_en (cu2_usable),
    .dec   (dec)
  );

  cp2_branch_eval #(.PC_W(PC_W)) u_br (
    .dec       (dec),
    .pc        (insn_pc),
    .unit_busy (vu_busy),
    .taken     (br_take),
    .squash    (br_squash),
    .seq_pc    (pc_seq),
    .target    (pc_tgt)
  );

  assign accept  = insn_valid && !stall;
  assign is_move = (dec.kind == CK_CTRL) || (dec.kind == CK_VEC);

  cp2_xfer_engine #(
    .AW(AW), .GW(GW), .STRIDE_LG(STRIDE_LG),
    .CTRL_BASE(CTRL_BASE), .VEC_BASE(VEC_BASE)
  ) u_xfer (
    .clk       (clk),
    .rst       (rst),
    .start     (accept && is_move),
    .dec       (dec),
    .src_word  (gpr_rdata),
    .unit_busy (vu_busy),
    .rd_word   (bus_rdata),
    .pending   (stall),
    .req       (bus_req),
    .req_we    (bus_we),
    .req_addr  (bus_addr),
    .req_wdata (bus_wdata),
    .wb_en     (gpr_we),
    .wb_idx    (gpr_waddr),
    .wb_data   (gpr_wdata),
    .fin       (x_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      local_done   <= 1'b0;
      next_pc      <= '0;
      br_taken     <= 1'b0;
      nullify_next <= 1'b0;
      exc_unusable <= 1'b0;
      exc_reserved <= 1'b0;
    end else begin
      local_done   <= 1'b0;
      br_taken     <= 1'b0;
      nullify_next <= 1'b0;
      exc_unusable <= 1'b0;
      exc_reserved <= 1'b0;
      if (accept) begin
        next_pc <= br_take ? pc_tgt : pc_seq;
        if (!is_move) begin
          local_done   <= 1'b1;
          br_taken     <= br_take;
          nullify_next <= br_squash;
          exc_unusable <= (dec.kind == CK_UNUSABLE);
          exc_reserved <= (dec.kind == CK_RESERVED);
        end
      end
    end
  end

  assign done = local_done | x_fin;
endmodule

// File: rtl/cp2_issue_checks.sv
module cp2_issue_checks #(
  parameter int GW = 64
) (
  input logic          clk,
  input logic          rst,
  input logic          stall,
  input logic          done,
  input logic          br_taken,
  input logic          nullify_next,
  input logic          exc_unusable,
  input logic          exc_reserved,
  input logic          bus_req,
  input logic          bus_we,
  input logic          gpr_we,
  input logic [GW-1:0] gpr_wdata
);
  AST_EXC_ALONE: assert property (@(posedge clk) disable iff (rst)
    (exc_unusable || exc_reserved) |-> (done && !bus_req && !gpr_we && !br_taken)); // R2

  AST_EXC_ONE_KIND: assert property (@(posedge clk) disable iff (rst)
    $onehot0({exc_unusable, exc_reserved, br_taken})); // R12

  AST_SQUASH_UNTAKEN: assert property (@(posedge clk) disable iff (rst)
    nullify_next |-> (done && !br_taken)); // R5

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
    bus_req |=> !bus_req); // R8

  AST_READ_THEN_WB: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_we) |=> (gpr_we && done)); // R9

  AST_WB_SIGNED: assert property (@(posedge clk) disable iff (rst)
    gpr_we |-> (gpr_wdata[GW-1:31] == '0 || gpr_wdata[GW-1:31] == '1)); // R9

  AST_STALL_START: assert property (@(posedge clk) disable iff (rst)
    $rose(stall) |-> (!done && !bus_req)); // R13
endmodule

bind cp2_issue_unit cp2_issue_checks #(.GW(GW)) u_checks (
  .clk          (clk),
  .rst          (rst),
  .stall        (stall),
  .done         (done),
  .br_taken     (br_taken),
  .nullify_next (nullify_next),
  .exc_unusable (exc_unusable),
  .exc_reserved (exc_reserved),
  .bus_req      (bus_req),
  .bus_we       (bus_we),
  .gpr_we       (gpr_we),
  .gpr_wdata    (gpr_wdata)
);

// File: tb/test_cp2_issue_unit.sv
module test_cp2_issue_unit;
  localparam logic [31:0] CB = 32'h0000_1000;
  localparam logic [31:0] VB = 32'h0000_1200;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        insn_valid = 1'b0;
  logic [25:0] insn = '0;
  logic [31:0] insn_pc = '0;
  logic        cu2_usable = 1'b1;
  logic        vu_busy = 1'b0;
  logic [31:0] gpr_rdata = '0;
  logic [31:0] bus_rdata = '0;
  logic        stall, done, br_taken, nullify_next, exc_unusable, exc_reserved;
  logic        bus_req, bus_we, gpr_we;
  logic [31:0] next_pc, bus_addr, bus_wdata;
  logic [4:0]  gpr_waddr;
  logic [63:0] gpr_wdata;

  always #5 clk = ~clk;

  cp2_issue_unit #(.CTRL_BASE(CB), .VEC_BASE(VB)) i_cp2_issue_unit (
    .clk(clk), .rst(rst), .insn_valid(insn_valid), .insn(insn), .insn_pc(insn_pc),
    .cu2_usable(cu2_usable), .vu_busy(vu_busy), .gpr_rdata(gpr_rdata),
    .bus_rdata(bus_rdata), .stall(stall), .done(done), .next_pc(next_pc),
    .br_taken(br_taken), .nullify_next(nullify_next), .exc_unusable(exc_unusable),
    .exc_reserved(exc_reserved), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .gpr_we(gpr_we),
    .gpr_waddr(gpr_waddr), .gpr_wdata(gpr_wdata)
  );

  int n_cmp = 0;
  int n_bad = 0;

  logic [31:0] mem [64];
  logic [31:0] shadow [64];
  logic [31:0] bus_off;
  assign bus_off = bus_addr - CB;

  always @(negedge clk) begin
    if (bus_req) begin
      if (bus_we) mem[bus_off[9:4]] <= bus_wdata;
      else        bus_rdata <= mem[bus_off[9:4]];
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // observations of one instruction
  int          o_done_c, o_req_c, o_wb_c, o_nreq;
  logic        o_taken, o_null, o_unus, o_res, o_req_we, o_stall1;
  logic [31:0] o_npc, o_addr, o_wdata;
  logic [4:0]  o_wb_idx;
  logic [63:0] o_wb_data;

  task automatic run(input logic [25:0] ins, input logic [31:0] pcv,
                     input logic [31:0] g, input logic cu, input int bz);
    @(negedge clk);
    insn = ins; insn_pc = pcv; gpr_rdata = g; cu2_usable = cu;
    vu_busy = (bz > 0); insn_valid = 1'b1;
    o_done_c = 0; o_req_c = 0; o_wb_c = 0; o_nreq = 0;
    o_taken = 0; o_null = 0; o_unus = 0; o_res = 0; o_req_we = 0; o_stall1 = 0;
    o_npc = '0; o_addr = '0; o_wdata = '0; o_wb_idx = '0; o_wb_data = '0;
    for (int c = 1; c <= 40; c++) begin
      @(posedge clk);
      #1 insn_valid = 1'b0;
      @(negedge clk);
      if (c == 1) o_stall1 = stall;
      if (bus_req) begin
        o_nreq++; o_req_c = c; o_req_we = bus_we; o_addr = bus_addr; o_wdata = bus_wdata;
      end
      if (gpr_we) begin
        o_wb_c = c; o_wb_idx = gpr_waddr; o_wb_data = gpr_wdata;
      end
      if (c == bz) vu_busy = 1'b0;
      if (done) begin
        o_done_c = c; o_taken = br_taken; o_null = nullify_next;
        o_unus = exc_unusable; o_res = exc_reserved; o_npc = next_pc;
        break;
      end
    end
    vu_busy = 1'b0;
  endtask

  task automatic check_insn(input logic [25:0] ins, input logic [31:0] pcv,
                            input logic [31:0] g, input logic cu, input int bz);
    logic [4:0]  op;
    logic [4:0]  sel;
    logic [31:0] tgt, addr;
    logic        busy0, tk, wr;
    int          reqc;
    run(ins, pcv, g, cu, bz);
    op = ins[25:21]; sel = ins[20:16]; busy0 = (bz > 0);
    tgt = pcv + 32'd4 + {{14{ins[15]}}, ins[15:0], 2'b00};
    if (!cu) begin
      chk("R2 unusable", {63'd0, o_unus}, 64'd1);
      chk("R2 done cycle", 64'(o_done_c), 64'd1);
      chk("R2 no bus/wb", 64'(o_nreq + o_wb_c), 64'd0);
    end else if (op == 5'h08 && sel < 5'd4) begin
      tk = sel[0] ? busy0 : !busy0;
      chk("R3 taken", {63'd0, o_taken}, {63'd0, tk});
      chk("R3 done cycle", 64'(o_done_c), 64'd1);
      chk("R4 next_pc", {32'd0, o_npc}, {32'd0, tk ? tgt : pcv + 32'd4});
      chk("R5 nullify", {63'd0, o_null}, {63'd0, sel[1] & !tk});
    end else if (((op == 5'h02 || op == 5'h06) && ins[10:1] == 10'd0) ||
                 op == 5'h01 || op == 5'h05) begin
      wr   = ins[23];
      addr = ((op == 5'h02 || op == 5'h06) ? CB : VB) + {22'd0, ins[15:11], 4'd0};
      reqc = ins[0] ? ((bz + 1 > 2) ? bz + 1 : 2) : 2;
      chk("R13 stall", {63'd0, o_stall1}, 64'd1);
      chk(ins[0] ? "R10 req cycle" : "R11 req cycle", 64'(o_req_c), 64'(reqc));
      chk((op == 5'h02 || op == 5'h06) ? "R6 addr" : "R7 addr", {32'd0, o_addr}, {32'd0, addr});
      chk("R4 next_pc move", {32'd0, o_npc}, {32'd0, pcv + 32'd4});
      chk("R8 one req", 64'(o_nreq), 64'd1);
      if (wr) begin
        chk("R8 we", {63'd0, o_req_we}, 64'd1);
        chk("R8 wdata", {32'd0, o_wdata}, {32'd0, g});
        chk("R8 done cycle", 64'(o_done_c), 64'(reqc));
        shadow[addr[9:4] - CB[9:4]] = g;
      end else begin
        chk("R9 wb cycle", 64'(o_wb_c), 64'(reqc + 1));
        chk("R9 wb idx", {59'd0, o_wb_idx}, {59'd0, ins[20:16]});
        chk("R9 wb data", o_wb_data,
            {{32{shadow[addr[9:4] - CB[9:4]][31]}}, shadow[addr[9:4] - CB[9:4]]});
      end
    end else begin
      chk("R12 reserved", {63'd0, o_res}, 64'd1);
      chk("R12 done cycle", 64'(o_done_c), 64'd1);
      chk("R12 no bus/wb", 64'(o_nreq + o_wb_c), 64'd0);
    end
  endtask

  function automatic logic [25:0] mk(input logic [4:0] op, input logic [4:0] rt,
                                     input logic [4:0] rd, input logic [9:0] mid,
                                     input logic lk);
    return {op, rt, rd, mid, lk};
  endfunction

  initial begin
    #1000000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int extra;
    void'($urandom(32'd20250611));
    for (int i = 0; i < 64; i++) begin
      mem[i] = 32'h8000_0003 ^ (32'(i) * 32'h0101_0107);
      shadow[i] = mem[i];
    end
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 stall", {63'd0, stall}, 64'd0);
    chk("R1 strobes", {58'd0, bus_req, gpr_we, br_taken, nullify_next, exc_unusable, exc_reserved}, 64'd0);

    // directed branches: R3 R4 R5
    check_insn({5'h08, 5'd0, 16'h8000}, 32'h0001_0000, 32'd0, 1'b1, 0);
    check_insn({5'h08, 5'd1, 16'h7fff}, 32'h0001_0000, 32'd0, 1'b1, 0);
    check_insn({5'h08, 5'd2, 16'hfffe}, 32'h0002_0040, 32'd0, 1'b1, 3);
    check_insn({5'h08, 5'd3, 16'h0010}, 32'h0002_0040, 32'd0, 1'b1, 0);
    check_insn({5'h08, 5'd3, 16'h0010}, 32'h0002_0040, 32'd0, 1'b1, 2);
    // R12 reserved forms
    check_insn({5'h08, 5'd4, 16'h0010}, 32'h100, 32'd0, 1'b1, 0);
    check_insn(mk(5'h02, 5'd3, 5'd2, 10'h001, 1'b0), 32'h100, 32'd0, 1'b1, 0);
    // R2 unusable
    check_insn(mk(5'h06, 5'd3, 5'd2, 10'h0, 1'b0), 32'h100, 32'd5, 1'b0, 0);
    // R6 R8 R9 R10 R11 moves
    check_insn(mk(5'h06, 5'd1, 5'd31, 10'h0, 1'b0), 32'h200, 32'hdead_beef, 1'b1, 50);
    check_insn(mk(5'h02, 5'd9, 5'd31, 10'h0, 1'b1), 32'h204, 32'd0, 1'b1, 4);
    check_insn(mk(5'h05, 5'd2, 5'd0, 10'h3ff, 1'b1), 32'h208, 32'h1234_5678, 1'b1, 1);
    check_insn(mk(5'h01, 5'd7, 5'd0, 10'h155, 1'b0), 32'h20c, 32'd0, 1'b1, 50);
    check_insn(mk(5'h01, 5'd8, 5'd5, 10'h0, 1'b0), 32'h210, 32'd0, 1'b1, 0);

    // R13 valid ignored during stall
    @(negedge clk);
    insn = mk(5'h06, 5'd0, 5'd3, 10'h0, 1'b1); gpr_rdata = 32'h1111_2222;
    insn_pc = 32'h300; cu2_usable = 1'b1; vu_busy = 1'b1; insn_valid = 1'b1;
    @(posedge clk);
    #1 insn = mk(5'h06, 5'd0, 5'd4, 10'h0, 1'b0); gpr_rdata = 32'h3333_4444;
    extra = 0;
    for (int c = 1; c <= 10; c++) begin
      @(negedge clk);
      if (bus_req) begin
        extra++;
        chk("R13 addr of held move", {32'd0, bus_addr}, {32'd0, CB + 32'h30});
      end
      if (c == 3) insn_valid = 1'b0;
      if (c == 5) vu_busy = 1'b0;
    end
    chk("R13 single request", 64'(extra), 64'd1);
    shadow[3] = 32'h1111_2222;
    check_insn(mk(5'h02, 5'd1, 5'd4, 10'h0, 1'b0), 32'h310, 32'd0, 1'b1, 0);
    check_insn(mk(5'h02, 5'd1, 5'd3, 10'h0, 1'b0), 32'h314, 32'd0, 1'b1, 0);

    // constrained random mix
    for (int i = 0; i < 400; i++) begin
      logic [25:0] ins;
      logic        cu;
      int          bz;
      int          cat;
      cat = int'($urandom % 5);
      case (cat)
        0: ins = {5'h08, ($urandom % 8 == 0) ? 5'($urandom) : 5'($urandom % 4), 16'($urandom)};
        1: ins = mk(($urandom % 2) ? 5'h06 : 5'h02, 5'($urandom), 5'($urandom),
                    ($urandom % 8 == 0) ? 10'($urandom) : 10'd0, 1'($urandom));
        2: ins = mk(($urandom % 2) ? 5'h05 : 5'h01, 5'($urandom), 5'($urandom),
                    10'($urandom), 1'($urandom));
        default: ins = 26'($urandom);
      endcase
      cu = ($urandom % 10) != 0;
      bz = ($urandom % 2) ? int'($urandom % 6) : 0;
      if (!ins[0] && ($urandom % 4 == 0)) bz = 50;
      check_insn(ins, $urandom & 32'hffff_fffc, $urandom, cu, bz);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule